// File: doc/BRIEF.md
# Adaptive Victim Write-Back Arbiter

This block sits beside one private cache of a four-processor cluster and decides what happens to each line that the cache evicts into its write-back queue. The decision is either to drop the line (it goes only to memory as usual) or to forward it to exactly one peer cache. The decision is made off the load/store critical path and takes a few cycles.

A victim is first screened on its own attributes: lines held in the shared coherence state, lines predicted to be reused rarely, and lines that were placed here by another cache and never touched are never forwarded. A surviving victim triggers one query to all peers, carrying the victim's set index and the local cache's replacement-interval history value (a larger value means a calmer cache with less demand for space). Each peer answers whether its LRU-position line in that set is predicted to be reused rarely, and with its own history value. A peer holding such a cold line wins first. Failing that, a peer whose history value is at least a factor `omega` above the local one is chosen. The factor `omega` adapts: it falls by one whenever a forwarded line is reused at a peer and rises by one after every third forwarded line.

Top module: `victim_wb_arbiter`

## Requirements
- R1: A victim offered with `vic_shared` high is never forwarded: one cycle after acceptance `dec_valid` is high with `dec_send` low, and no query is issued.
- R2: A victim offered with `vic_low_reuse` high is never forwarded, with the same timing as R1.
- R3: A victim offered with `vic_foreign_unused` high is never forwarded, with the same timing as R1.
- R4: Any other accepted victim raises `qry_valid` for one cycle, one cycle after acceptance, with `qry_set` equal to the victim's set and `qry_hist` equal to `local_hist` at acceptance; the decision appears one cycle after the cycle in which `rsp_valid` is high.
- R5: If any peer sets its bit of `rsp_low_lru` (bit i belongs to processor i), the victim goes to the lowest-numbered such peer, whatever the history values.
- R6: Otherwise the victim goes to the lowest-numbered peer whose history field (bits i*HIST_W upward of `rsp_hist`) is greater than or equal to `omega` times the queried local history; if no peer qualifies, `dec_send` is low.
- R7: The response bits and history field at index LOCAL_ID (the cache's own position) are ignored; `dec_target` never equals LOCAL_ID when `dec_send` is high.
- R8: `omega` resets to 2, decreases by one on each cycle with `reuse_evt` high, and never falls below 1.
- R9: Every third forwarded victim increases `omega` by one, capped at 7; the count of forwarded victims restarts after each third one, also when `omega` is already at its cap.
- R10: When the third forward and a `reuse_evt` fall on the same cycle, `omega` is unchanged and the forward count still restarts.
- R11: `vic_valid` is ignored while `vic_ready` is low (from query until decision); it produces no extra decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vic_valid | input | 1 | Victim offered this cycle |
| vic_ready | output | 1 | Arbiter can accept a victim |
| vic_set | input | SET_W | Set index of the victim |
| vic_shared | input | 1 | Victim in shared coherence state |
| vic_low_reuse | input | 1 | Victim predicted rarely reused |
| vic_foreign_unused | input | 1 | Victim came from a peer and was never used |
| local_hist | input | HIST_W | Local replacement-interval history |
| qry_valid | output | 1 | Query to peers |
| qry_set | output | SET_W | Set index carried by the query |
| qry_hist | output | HIST_W | Local history carried by the query |
| rsp_valid | input | 1 | All peer answers present |
| rsp_low_lru | input | NUM_CPU | Per peer: cold line at LRU position of that set |
| rsp_hist | input | NUM_CPU*HIST_W | Per peer history values |
| reuse_evt | input | 1 | A line forwarded by this cache was reused |
| dec_valid | output | 1 | Decision strobe |
| dec_send | output | 1 | Forward the victim |
| dec_target | output | ID_W | Peer that receives the victim |

## Verification
A screened-out victim has its decision one cycle after the acceptance edge, so the bench samples `dec_valid` at the falling edge after that clock and checks that `qry_valid` stayed low there. A surviving victim shows its query in that same sample, and its decision at the falling edge following the clock that saw `rsp_valid`; one cycle later `dec_valid` must be low again. `omega` updates on the clock that registers a forward or sees `reuse_evt`, so the bench's own copy of `omega` and the forward count is advanced there, and probes just below and exactly at the threshold confirm the value before the next change.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUERY = 2'd1,
    ST_WAIT  = 2'd2
  } vwb_state_t;

endpackage

// File: rtl/vwb_lowest_pick.sv
module vwb_lowest_pick #(
  parameter int N   = 4,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   req_i,
  output logic           any_o,
  output logic [IDW-1:0] idx_o,
  output logic [N-1:0]   grant_o
);

  // Scan from the top down so the lowest requester overwrites last.
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IDW'(i);
        grant_o = N'(1) << i;
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/vwb_demand_cmp.sv
module vwb_demand_cmp #(
  parameter int NUM_CPU = 4,
  parameter int HIST_W  = 8,
  parameter int W_W     = 3
) (
  input  logic [W_W-1:0]            omega_i,
  input  logic [HIST_W-1:0]         local_hist_i,
  input  logic [NUM_CPU*HIST_W-1:0] peer_hist_i,
  output logic [NUM_CPU-1:0]        pass_o
);

  localparam int PROD_W = HIST_W + W_W;

  logic [PROD_W-1:0] thresh;

  assign thresh = {{HIST_W{1'b0}}, omega_i} * {{W_W{1'b0}}, local_hist_i};

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_peer
    logic [PROD_W-1:0] peer_ext;
    assign peer_ext  = {{W_W{1'b0}}, peer_hist_i[g*HIST_W +: HIST_W]};
    assign pass_o[g] = (peer_ext >= thresh);
  end

endmodule

// File: rtl/vwb_omega_ctrl.sv
module vwb_omega_ctrl #(
  parameter int OMEGA_MIN  = 1,
  parameter int OMEGA_MAX  = 7,
  parameter int OMEGA_INIT = 2,
  parameter int WB_STEP    = 3,
  parameter int W_W        = $clog2(OMEGA_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wb_evt_i,
  input  logic           reuse_evt_i,
  output logic [W_W-1:0] omega_o
);

  localparam int CNT_W = (WB_STEP > 1) ? $clog2(WB_STEP) : 1;
  localparam logic [W_W-1:0]   W_MIN  = W_W'(OMEGA_MIN);
  localparam logic [W_W-1:0]   W_MAX  = W_W'(OMEGA_MAX);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WB_STEP - 1);

  logic [W_W-1:0]   omega_q, omega_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             step_hit;
  logic             upd_en;

  assign step_hit = wb_evt_i && (cnt_q == CNT_LAST);
  assign upd_en   = wb_evt_i || reuse_evt_i;

  always_comb begin
    cnt_n   = cnt_q;
    omega_n = omega_q;
    if (wb_evt_i) begin
      cnt_n = step_hit ? '0 : cnt_q + CNT_W'(1);
    end
    if (step_hit && !reuse_evt_i) begin
      if (omega_q < W_MAX) omega_n = omega_q + W_W'(1);
    end else if (reuse_evt_i && !step_hit) begin
      if (omega_q > W_MIN) omega_n = omega_q - W_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      omega_q <= W_W'(OMEGA_INIT);
      cnt_q   <= '0;
    end else if (upd_en) begin
      omega_q <= omega_n;
      cnt_q   <= cnt_n;
    end
  end

  assign omega_o = omega_q;

  assert_omega_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (omega_q >= W_MIN) && (omega_q <= W_MAX));

  assert_reuse_lowers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reuse_evt_i && !wb_evt_i) |=>
      (omega_q == (($past(omega_q) > W_MIN) ? $past(omega_q) - W_W'(1) : W_MIN)));

  assert_step_raises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_hit && !reuse_evt_i) |=>
      (cnt_q == '0) &&
      (omega_q == (($past(omega_q) < W_MAX) ? $past(omega_q) + W_W'(1) : W_MAX)));

  assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_hit && reuse_evt_i) |=> $stable(omega_q) && (cnt_q == '0));

endmodule

// File: rtl/victim_wb_arbiter.sv
module victim_wb_arbiter
  import vwb_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int LOCAL_ID   = 0,
  parameter int SET_W      = 6,
  parameter int HIST_W     = 8,
  parameter int OMEGA_MIN  = 1,
  parameter int OMEGA_MAX  = 7,
  parameter int OMEGA_INIT = 2,
  parameter int WB_STEP    = 3,
  parameter int ID_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vic_valid,
  output logic                      vic_ready,
  input  logic [SET_W-1:0]          vic_set,
  input  logic                      vic_shared,
  input  logic                      vic_low_reuse,
  input  logic                      vic_foreign_unused,
  input  logic [HIST_W-1:0]         local_hist,
  output logic                      qry_valid,
  output logic [SET_W-1:0]          qry_set,
  output logic [HIST_W-1:0]         qry_hist,
  input  logic                      rsp_valid,
  input  logic [NUM_CPU-1:0]        rsp_low_lru,
  input  logic [NUM_CPU*HIST_W-1:0] rsp_hist,
  input  logic                      reuse_evt,
  output logic                      dec_valid,
  output logic                      dec_send,
  output logic [ID_W-1:0]           dec_target
);

  localparam int W_W = $clog2(OMEGA_MAX + 1);
  localparam logic [NUM_CPU-1:0] PEER_MASK = ~(NUM_CPU'(1) << LOCAL_ID);
  localparam logic [ID_W-1:0]    SELF_ID   = ID_W'(LOCAL_ID);

  vwb_state_t state_q, state_n;

  logic [SET_W-1:0]  set_q;
  logic [HIST_W-1:0] hist_q;
  logic              cap_en;

  logic              dv_q, dv_n;
  logic              ds_q, ds_n;
  logic [ID_W-1:0]   dt_q, dt_n;
  logic              dec_en;

  logic              screened;
  logic              take_vic;
  logic              resolve;

  logic [W_W-1:0]     omega;
  logic [NUM_CPU-1:0] dem_pass;
  logic [NUM_CPU-1:0] cold_req, dem_req;
  logic               cold_any, dem_any;
  logic [ID_W-1:0]    cold_idx, dem_idx;
  logic [NUM_CPU-1:0] cold_gnt, dem_gnt;
  logic               fwd_sel;
  logic [ID_W-1:0]    fwd_idx;
  logic               wb_evt;

  assign vic_ready = (state_q == ST_IDLE);
  assign screened  = vic_shared || vic_low_reuse || vic_foreign_unused;
  assign take_vic  = vic_valid && vic_ready;
  assign resolve   = (state_q == ST_WAIT) && rsp_valid;

  vwb_demand_cmp #(
    .NUM_CPU (NUM_CPU),
    .HIST_W  (HIST_W),
    .W_W     (W_W)
  ) u_demand_cmp (
    .omega_i      (omega),
    .local_hist_i (hist_q),
    .peer_hist_i  (rsp_hist),
    .pass_o       (dem_pass)
  );

  assign cold_req = rsp_low_lru & PEER_MASK;
  assign dem_req  = dem_pass & PEER_MASK;

  vwb_lowest_pick #(.N(NUM_CPU), .IDW(ID_W)) u_pick_cold (
    .req_i   (cold_req),
    .any_o   (cold_any),
    .idx_o   (cold_idx),
    .grant_o (cold_gnt)
  );

  vwb_lowest_pick #(.N(NUM_CPU), .IDW(ID_W)) u_pick_dem (
    .req_i   (dem_req),
    .any_o   (dem_any),
    .idx_o   (dem_idx),
    .grant_o (dem_gnt)
  );

  // Cold LRU line at a peer outranks the demand comparison.
  assign fwd_sel = cold_any || dem_any;
  assign fwd_idx = cold_any ? cold_idx : dem_idx;
  assign wb_evt  = resolve && fwd_sel;

  vwb_omega_ctrl #(
    .OMEGA_MIN  (OMEGA_MIN),
    .OMEGA_MAX  (OMEGA_MAX),
    .OMEGA_INIT (OMEGA_INIT),
    .WB_STEP    (WB_STEP),
    .W_W        (W_W)
  ) u_omega (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_evt_i    (wb_evt),
    .reuse_evt_i (reuse_evt),
    .omega_o     (omega)
  );

  always_comb begin
    state_n = state_q;
    cap_en  = 1'b0;
    dv_n    = 1'b0;
    ds_n    = ds_q;
    dt_n    = dt_q;
    dec_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (vic_valid) begin
          if (screened) begin
            dv_n   = 1'b1;
            ds_n   = 1'b0;
            dt_n   = '0;
            dec_en = 1'b1;
          end else begin
            cap_en  = 1'b1;
            state_n = ST_QUERY;
          end
        end
      end
      ST_QUERY: begin
        state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          dv_n    = 1'b1;
          ds_n    = fwd_sel;
          dt_n    = fwd_sel ? fwd_idx : '0;
          dec_en  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: begin
        state_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dv_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      dv_q    <= dv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      hist_q <= '0;
    end else if (cap_en) begin
      set_q  <= vic_set;
      hist_q <= local_hist;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q <= 1'b0;
      dt_q <= '0;
    end else if (dec_en) begin
      ds_q <= ds_n;
      dt_q <= dt_n;
    end
  end

  assign qry_valid  = (state_q == ST_QUERY);
  assign qry_set    = set_q;
  assign qry_hist   = hist_q;
  assign dec_valid  = dv_q;
  assign dec_send   = ds_q;
  assign dec_target = dt_q;

  // R2 and R3 share this check with R1: all three screens act alike.
  assert_screened_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vic && screened) |=> (dec_valid && !dec_send && !qry_valid));

  assert_query_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vic && !screened) |=>
      (qry_valid && !dec_valid && (qry_set == $past(vic_set)) &&
       (qry_hist == $past(local_hist))));

  assert_decision_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resolve |=> dec_valid);

  assert_cold_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && ((rsp_low_lru & PEER_MASK) != '0)) |=>
      (dec_send && ((($past(rsp_low_lru) >> dec_target) & NUM_CPU'(1)) != '0)));

  assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cold_gnt) && $onehot0(dem_gnt));

  assert_never_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_send) |-> (dec_target != SELF_ID));

  assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && !rsp_valid) |=> (state_q == ST_WAIT) && !dec_valid);

endmodule

// File: tb/test_victim_wb_arbiter.sv
module test_victim_wb_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CPU = 4;
  localparam int SET_W   = 6;
  localparam int HIST_W  = 8;
  localparam int ID_W    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vic_valid = 1'b0;
  logic vic_ready;
  logic [SET_W-1:0] vic_set = '0;
  logic vic_shared = 1'b0;
  logic vic_low_reuse = 1'b0;
  logic vic_foreign_unused = 1'b0;
  logic [HIST_W-1:0] local_hist = '0;
  logic qry_valid;
  logic [SET_W-1:0] qry_set;
  logic [HIST_W-1:0] qry_hist;
  logic rsp_valid = 1'b0;
  logic [NUM_CPU-1:0] rsp_low_lru = '0;
  logic [NUM_CPU*HIST_W-1:0] rsp_hist = '0;
  logic reuse_evt = 1'b0;
  logic dec_valid;
  logic dec_send;
  logic [ID_W-1:0] dec_target;

  int checks = 0;
  int errors = 0;
  int m_omega = 2;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_wb_arbiter i_victim_wb_arbiter (
    .clk(clk), .rst_n(rst_n),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_set(vic_set),
    .vic_shared(vic_shared), .vic_low_reuse(vic_low_reuse),
    .vic_foreign_unused(vic_foreign_unused), .local_hist(local_hist),
    .qry_valid(qry_valid), .qry_set(qry_set), .qry_hist(qry_hist),
    .rsp_valid(rsp_valid), .rsp_low_lru(rsp_low_lru), .rsp_hist(rsp_hist),
    .reuse_evt(reuse_evt),
    .dec_valid(dec_valid), .dec_send(dec_send), .dec_target(dec_target)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model update for one clock: forward and/or reuse.
  task automatic model_step(input bit fwd, input bit reu);
    bit inc = 1'b0;
    if (fwd) begin
      m_cnt++;
      if (m_cnt == 3) begin
        m_cnt = 0;
        inc = 1'b1;
      end
    end
    if (inc && !reu && m_omega < 7) m_omega++;
    if (reu && !inc && m_omega > 1) m_omega--;
  endtask

  // Offers one victim and checks query and decision against the model.
  task automatic run_vic(input bit sh, input bit lr, input bit fu,
                         input logic [SET_W-1:0] st, input logic [7:0] lh,
                         input logic [3:0] lowm, input logic [31:0] hs,
                         input bit reu, input string tag);
    bit filt = sh || lr || fu;
    bit exp_send = 1'b0;
    int exp_tgt = 0;
    logic [3:0] cold = lowm & 4'b1110;
    if (cold != 0) begin
      exp_send = 1'b1;
      for (int i = 3; i >= 1; i--) if (cold[i]) exp_tgt = i;
    end else begin
      for (int i = 3; i >= 1; i--)
        if (int'(hs[i*8 +: 8]) >= m_omega * int'(lh)) begin
          exp_send = 1'b1;
          exp_tgt = i;
        end
    end
    @(negedge clk);
    vic_valid = 1'b1; vic_set = st; vic_shared = sh; vic_low_reuse = lr;
    vic_foreign_unused = fu; local_hist = lh;
    @(negedge clk);
    vic_valid = 1'b0; vic_shared = 1'b0; vic_low_reuse = 1'b0; vic_foreign_unused = 1'b0;
    local_hist = 8'd99;
    if (filt) begin
      check(dec_valid == 1'b1, {tag, " screened decision due"}, int'(dec_valid), 1);
      check(dec_send == 1'b0, {tag, " screened not sent"}, int'(dec_send), 0);
      check(qry_valid == 1'b0, {tag, " screened no query"}, int'(qry_valid), 0);
    end else begin
      check(qry_valid == 1'b1, {tag, " R4 query raised"}, int'(qry_valid), 1);
      check(qry_set == st, {tag, " R4 query set"}, int'(qry_set), int'(st));
      check(qry_hist == lh, {tag, " R4 query hist"}, int'(qry_hist), int'(lh));
      check(dec_valid == 1'b0, {tag, " R4 no early decision"}, int'(dec_valid), 0);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_low_lru = lowm; rsp_hist = hs; reuse_evt = reu;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_low_lru = '0; rsp_hist = '0; reuse_evt = 1'b0;
      model_step(exp_send, reu);
      check(dec_valid == 1'b1, {tag, " R4 decision due"}, int'(dec_valid), 1);
      check(dec_send == exp_send, {tag, " send"}, int'(dec_send), int'(exp_send));
      if (exp_send)
        check(int'(dec_target) == exp_tgt, {tag, " target"}, int'(dec_target), exp_tgt);
    end
    @(negedge clk);
    check(dec_valid == 1'b0, {tag, " R4 single strobe"}, int'(dec_valid), 0);
  endtask

  task automatic pulse_reuse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); reuse_evt = 1'b1;
      @(negedge clk); reuse_evt = 1'b0;
      model_step(1'b0, 1'b1);
    end
  endtask

  // Probe just below and at the threshold for peer 1 with local history 10.
  task automatic probe_omega(input string tag);
    logic [7:0] at = 8'(10 * m_omega);
    run_vic(0, 0, 0, 6'd5, 8'd10, 4'b0000, {16'd0, at - 8'd1, 8'd0}, 0, {tag, " below"});
    at = 8'(10 * m_omega);
    run_vic(0, 0, 0, 6'd5, 8'd10, 4'b0000, {16'd0, at, 8'd0}, 0, {tag, " at"});
  endtask

  task automatic t_reset;
    check(dec_valid == 1'b0, "reset R4 dec_valid", int'(dec_valid), 0);
    check(qry_valid == 1'b0, "reset R4 qry_valid", int'(qry_valid), 0);
    check(vic_ready == 1'b1, "reset R11 vic_ready", int'(vic_ready), 1);
  endtask

  task automatic t_screens;
    run_vic(1, 0, 0, 6'd3, 8'd10, 4'b1110, {8'd255, 8'd255, 8'd255, 8'd0}, 0, "R1 shared");
    run_vic(0, 1, 0, 6'd4, 8'd10, 4'b1110, {8'd255, 8'd255, 8'd255, 8'd0}, 0, "R2 low reuse");
    run_vic(0, 0, 1, 6'd9, 8'd10, 4'b1110, {8'd255, 8'd255, 8'd255, 8'd0}, 0, "R3 foreign unused");
  endtask

  task automatic t_cold;
    run_vic(0, 0, 0, 6'd17, 8'd10, 4'b1100, {8'd0, 8'd0, 8'd200, 8'd0}, 0, "R5 cold over demand");
    run_vic(0, 0, 0, 6'd33, 8'd10, 4'b1000, {8'd0, 8'd0, 8'd0, 8'd0}, 0, "R5 cold only peer3");
  endtask

  task automatic t_self;
    run_vic(0, 0, 0, 6'd2, 8'd10, 4'b0001, {8'd0, 8'd0, 8'd0, 8'd250}, 0, "R7 self ignored");
  endtask

  task automatic t_demand;
    run_vic(0, 0, 0, 6'd7, 8'd10, 4'b0000, {8'd250, 8'd250, 8'd0, 8'd0}, 0, "R6 lowest passing");
    run_vic(0, 0, 0, 6'd8, 8'd40, 4'b0000, {8'd1, 8'd2, 8'd3, 8'd0}, 0, "R6 none passes");
    probe_omega("R6 boundary");
  endtask

  task automatic t_raise;
    for (int k = 0; k < 8; k++) probe_omega("R9 raise");
    probe_omega("R9 cap");
  endtask

  task automatic t_lower;
    pulse_reuse(3);
    probe_omega("R8 lowered");
    pulse_reuse(9);
    probe_omega("R8 floor");
  endtask

  task automatic t_cancel;
    pulse_reuse(2);
    while (m_cnt != 2)
      run_vic(0, 0, 0, 6'd1, 8'd10, 4'b0010, 32'd0, 0, "R10 fill");
    run_vic(0, 0, 0, 6'd1, 8'd10, 4'b0010, 32'd0, 1, "R10 third with reuse");
    probe_omega("R10 after cancel");
  endtask

  task automatic t_busy;
    @(negedge clk);
    vic_valid = 1'b1; vic_set = 6'd21; local_hist = 8'd10;
    @(negedge clk);
    vic_valid = 1'b1; vic_shared = 1'b1; vic_set = 6'd50;
    check(qry_valid == 1'b1, "R11 query raised", int'(qry_valid), 1);
    @(negedge clk);
    check(vic_ready == 1'b0, "R11 not ready while waiting", int'(vic_ready), 0);
    check(dec_valid == 1'b0, "R11 busy offer makes no decision", int'(dec_valid), 0);
    vic_valid = 1'b0; vic_shared = 1'b0;
    rsp_valid = 1'b1; rsp_low_lru = 4'b0100;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_low_lru = '0;
    model_step(1'b1, 1'b0);
    check(dec_valid == 1'b1 && dec_send == 1'b1, "R11 original decision", int'(dec_send), 1);
    check(dec_target == 2'd2, "R11 original target", int'(dec_target), 2);
    @(negedge clk);
    check(dec_valid == 1'b0, "R11 no extra decision", int'(dec_valid), 0);
    @(negedge clk);
    check(dec_valid == 1'b0 && qry_valid == 1'b0, "R11 offer dropped", int'(dec_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_screens();
    t_cold();
    t_self();
    t_demand();
    t_raise();
    t_lower();
    t_cancel();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule